// File: doc/BRIEF.md
# Eight-bit synchronous serial port

This block moves one byte at a time over a three-wire synchronous link: a serial clock, a data input and a data output. There is no select line. A transfer is framed only by the clock: the clock rests high, its first falling edge opens a transfer, and the eighth rising edge closes it. Output bits change on falling edges and input bits are captured on rising edges. The host loads the byte to send with a write strobe, reads the received byte from a data port, and watches a completion flag.

In master mode the block makes the serial clock itself, dividing the system clock by a rate code. In slave mode the clock comes from outside. It passes through a synchroniser, and its edges, found in the system clock domain, drive the same shift and capture logic. A configuration input selects the bit order, most significant bit first or least significant bit first.

The control state machine has four states:
- `ST_OFF`: the port is disabled.
- `ST_IDLE`: the port is enabled and waits for a first falling edge.
- `ST_LOW`: a bit has been launched and the block waits for its rising edge.
- `ST_HIGH`: a bit has been captured and the block waits for the next falling edge.

The transitions are:
- OFF→IDLE when enable rises.
- IDLE→LOW on an accepted falling edge.
- LOW→HIGH on a rising edge of bits 1 to 7.
- LOW→IDLE on the eighth rising edge.
- HIGH→LOW on a falling edge.
- Any state→OFF when enable is low.

Top module: `sio_byte_port`

## Requirements
- R1: After reset, `done_flag` is 0, `sck_out` is 1 and `sdo` is 1. While no transfer is running, `sck_out` stays 1.
- R2: In master mode, a write accepted while the port is idle starts a transfer. Each low and each high phase of `sck_out` lasts 1, 2, 8 or 16 system clock cycles for `cfg_rate` codes 0, 1, 2 and 3.
- R3: `sdo` changes only at a falling edge of the serial clock. The first data bit appears at the first falling edge, and each later bit appears at a later falling edge.
- R4: `sdi` is captured at each rising edge of the serial clock. After eight rising edges, `host_rdata` holds the eight captured bits in the selected order. With MSB-first order (`cfg_lsb_first`=0), the first bit captured is bit 7.
- R5: `done_flag` rises at the eighth rising edge. After that, `sck_out` stays 1 and makes no further edges.
- R6: With `cfg_lsb_first`=1, bit 0 of the written byte is sent first, and the first bit captured lands in bit 0 of `host_rdata`.
- R7: In slave mode, `sck_out` stays 1 and `sck_oe` is 0. Falling and rising edges of `sck_in` drive the transfer, and they are seen two system clock cycles late because of the synchroniser.
- R8: A `host_wr` pulse during a running transfer is ignored. Neither the bits sent nor the byte received are changed.
- R9: `done_flag` is cleared by a `host_rd` pulse or by an accepted `host_wr`.
- R10: While `cfg_enable` is 0, writes are ignored and no transfer runs or starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Port enable |
| cfg_master | input | 1 | 1 = master (internal clock), 0 = slave (external clock) |
| cfg_lsb_first | input | 1 | 1 = least significant bit first, 0 = most significant bit first |
| cfg_rate | input | 2 | Master clock division code: 0 = /2, 1 = /4, 2 = /16, 3 = /32 |
| host_wr | input | 1 | Write strobe: loads the byte to send and, in master mode, starts a transfer |
| host_wdata | input | 8 | Byte to send |
| host_rd | input | 1 | Read strobe: clears the completion flag |
| host_rdata | output | 8 | Shift register contents, holding the received byte once the flag is set |
| done_flag | output | 1 | Transfer complete |
| sck_in | input | 1 | External serial clock (slave mode) |
| sck_out | output | 1 | Generated serial clock (master mode) |
| sck_oe | output | 1 | Drive enable for the serial clock pin |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, from the last shift stage |
| sdo_oe | output | 1 | Drive enable for the serial data output |

## Verification
The hardest case to reach from the ports is a host write that lands in the middle of a running transfer. The bench acts as the peer device and, in master mode, pulses `host_wr` with a different byte just after the third rising edge. It then confirms that the remaining bits and the received byte still match the original values. The slave path is also hard to drive, because its latency comes from the synchroniser. The bench drives `sck_in` itself with half periods of six system clock cycles, and samples `sdo` just before each rising edge it makes. Rate codes, bit order and data come from a seeded `$urandom`, alongside directed runs of every rate in both orders.

// File: rtl/sio_pkg.sv
package sio_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_IDLE = 2'd1,
        ST_LOW  = 2'd2,
        ST_HIGH = 2'd3
    } sio_state_t;

    localparam int RATE_W     = 2;
    localparam int HALF_CNT_W = 5;

    // System clock cycles per serial clock half period for each rate code.
    function automatic logic [HALF_CNT_W-1:0] half_period(input logic [RATE_W-1:0] code);
        logic [HALF_CNT_W-1:0] h;
        unique case (code)
            2'd0:    h = HALF_CNT_W'(1);
            2'd1:    h = HALF_CNT_W'(2);
            2'd2:    h = HALF_CNT_W'(8);
            default: h = HALF_CNT_W'(16);
        endcase
        return h;
    endfunction

endpackage

// File: rtl/sio_rate_gen.sv
module sio_rate_gen
    import sio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              sck,
    output logic              fall_ev,
    output logic              rise_ev
);
    logic [HALF_CNT_W-1:0] cnt_q;
    logic [HALF_CNT_W-1:0] half;
    logic                  expire;

    assign half    = half_period(rate);
    assign expire  = run && (cnt_q == half - HALF_CNT_W'(1));
    assign fall_ev = expire && sck;
    assign rise_ev = expire && !sck;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sck   <= 1'b1;
        end else if (!run) begin
            cnt_q <= '0;
            sck   <= 1'b1;
        end else if (expire) begin
            cnt_q <= '0;
            sck   <= ~sck;
        end else begin
            cnt_q <= cnt_q + HALF_CNT_W'(1);
        end
    end
endmodule

// File: rtl/sio_edge_sync.sv
module sio_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall_ev,
    output logic rise_ev
);
    // Stages 0..STAGES-1 synchronise; the extra stage holds the previous value.
    logic [STAGES:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[STAGES-1:0], pin};
    end

    assign fall_ev =  sync_q[STAGES] && !sync_q[STAGES-1];
    assign rise_ev = !sync_q[STAGES] &&  sync_q[STAGES-1];
endmodule

// File: rtl/sio_shift_core.sv
module sio_shift_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         lsb_first,
    input  logic         shift_out,
    input  logic         shift_in,
    input  logic         sdi,
    output logic [W-1:0] sr_q,
    output logic         sdo_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q  <= '0;
            sdo_q <= 1'b1;
        end else if (load) begin
            sr_q <= load_data;
        end else if (shift_out) begin
            // Launch one bit into the output stage and open a slot for the incoming bit.
            if (lsb_first) begin
                sdo_q <= sr_q[0];
                sr_q  <= {1'b0, sr_q[W-1:1]};
            end else begin
                sdo_q <= sr_q[W-1];
                sr_q  <= {sr_q[W-2:0], 1'b0};
            end
        end else if (shift_in) begin
            if (lsb_first) sr_q[W-1] <= sdi;
            else           sr_q[0]   <= sdi;
        end
    end
endmodule

// File: rtl/sio_byte_port.sv
module sio_byte_port
    import sio_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_master,
    input  logic              cfg_lsb_first,
    input  logic [RATE_W-1:0] cfg_rate,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd,
    output logic [DATA_W-1:0] host_rdata,
    output logic              done_flag,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    sio_state_t        state_q, state_d;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic              m_run_q;
    logic              gen_run;
    logic              m_fall, m_rise, s_fall, s_rise;
    logic              fall_ev, rise_ev;
    logic              wr_ok, shift_fall, shift_rise, last_bit;
    logic              xfer_active;
    logic [DATA_W-1:0] sr;
    logic              sdo_q;

    // Serial clock sources
    assign gen_run = m_run_q && cfg_enable && cfg_master;

    sio_rate_gen u_rate (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (gen_run),
        .rate    (cfg_rate),
        .sck     (sck_out),
        .fall_ev (m_fall),
        .rise_ev (m_rise)
    );

    sio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin     (sck_in),
        .fall_ev (s_fall),
        .rise_ev (s_rise)
    );

    assign fall_ev = cfg_enable && (cfg_master ? m_fall : s_fall);
    assign rise_ev = cfg_enable && (cfg_master ? m_rise : s_rise);

    // Accepted events
    assign xfer_active = (state_q == ST_LOW) || (state_q == ST_HIGH) || m_run_q;
    assign wr_ok       = host_wr && cfg_enable && (state_q == ST_IDLE) && !m_run_q;
    assign shift_fall  = fall_ev && !wr_ok &&
                         ((state_q == ST_IDLE) || (state_q == ST_HIGH));
    assign shift_rise  = rise_ev && (state_q == ST_LOW);
    assign last_bit    = (bit_cnt_q == LAST_BIT);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  if (cfg_enable) state_d = ST_IDLE;
            ST_IDLE: if (shift_fall) state_d = ST_LOW;
            ST_LOW:  if (shift_rise) state_d = last_bit ? ST_IDLE : ST_HIGH;
            ST_HIGH: if (shift_fall) state_d = ST_LOW;
            default: state_d = ST_OFF;
        endcase
        if (!cfg_enable) state_d = ST_OFF;
    end

    // Bit counter, master run request and completion flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            m_run_q   <= 1'b0;
            done_flag <= 1'b0;
        end else begin
            if (state_q == ST_IDLE || state_q == ST_OFF) bit_cnt_q <= '0;
            else if (shift_rise)                         bit_cnt_q <= bit_cnt_q + CNT_W'(1);

            if (!cfg_enable || !cfg_master)        m_run_q <= 1'b0;
            else if (wr_ok)                        m_run_q <= 1'b1;
            else if (shift_rise && last_bit)       m_run_q <= 1'b0;

            if (shift_rise && last_bit)            done_flag <= 1'b1;
            else if (host_rd || wr_ok)             done_flag <= 1'b0;
        end
    end

    sio_shift_core #(.W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wr_ok),
        .load_data (host_wdata),
        .lsb_first (cfg_lsb_first),
        .shift_out (shift_fall),
        .shift_in  (shift_rise),
        .sdi       (sdi),
        .sr_q      (sr),
        .sdo_q     (sdo_q)
    );

    // Pin and host outputs
    assign host_rdata = sr;
    assign sdo        = sdo_q;
    assign sdo_oe     = cfg_enable;
    assign sck_oe     = cfg_enable && cfg_master;
endmodule

// File: rtl/sio_port_checker.sv
module sio_port_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_enable,
    input logic cfg_master,
    input logic host_rd,
    input logic sck_out,
    input logic sdo,
    input logic done_flag,
    input logic active
);
    p_idle_clock_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> sck_out);

    p_sdo_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && !$stable(sdo)) |-> $fell(sck_out));

    p_done_with_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && $rose(done_flag)) |-> $rose(sck_out));

    p_slave_clock_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_master |-> sck_out);

    p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && host_rd && !active) |=> !done_flag);

    p_disabled_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> !active);
endmodule

bind sio_byte_port sio_port_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_enable (cfg_enable),
    .cfg_master (cfg_master),
    .host_rd    (host_rd),
    .sck_out    (sck_out),
    .sdo        (sdo),
    .done_flag  (done_flag),
    .active     (xfer_active)
);

// File: tb/sio_byte_port_bench.sv
module sio_byte_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_enable = 1'b0, cfg_master = 1'b1, cfg_lsb_first = 1'b0;
    logic [1:0] cfg_rate = 2'd0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       done_flag, sck_in = 1'b1, sck_out, sck_oe, sdi = 1'b0, sdo, sdo_oe;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    sio_byte_port u_sio_byte_port (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_master(cfg_master),
        .cfg_lsb_first(cfg_lsb_first), .cfg_rate(cfg_rate), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
        .done_flag(done_flag), .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
        .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    function automatic logic exp_bit(input logic [7:0] b, input logic lsb, input int i);
        return lsb ? b[i] : b[7-i];
    endfunction

    function automatic int half_of(input logic [1:0] r);
        case (r)
            2'd0:    return 1;
            2'd1:    return 2;
            2'd2:    return 8;
            default: return 16;
        endcase
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_write(input logic [7:0] d);
        @(negedge clk);
        host_wdata = d;
        host_wr    = 1'b1;
        @(negedge clk);
        host_wr    = 1'b0;
    endtask

    task automatic do_read;
        @(negedge clk);
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        check(done_flag == 1'b0, "R9 read clears flag", done_flag, 0);
    endtask

    // The bench plays the peer device on the master's clock.
    task automatic run_master(input logic [1:0] rate, input logic lsb,
                              input logic [7:0] tx, input logic [7:0] peer, input logic mid_wr);
        logic prev;
        int   fidx, ridx, lowcnt, first_low, bad_bits, cyc;
        logic had_done;
        cfg_master = 1'b1; cfg_rate = rate; cfg_lsb_first = lsb;
        had_done = done_flag;
        @(negedge clk);
        host_wdata = tx; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
        if (had_done) check(done_flag == 1'b0, "R9 write clears flag", done_flag, 0);
        prev = 1'b1; fidx = 0; ridx = 0; lowcnt = 0; first_low = -1; bad_bits = 0; cyc = 0;
        while (ridx < 8 && cyc < 2000) begin
            host_wr = 1'b0;
            if (prev && !sck_out) begin
                sdi = exp_bit(peer, lsb, fidx);
                fidx++;
                lowcnt = 0;
            end
            if (!sck_out) lowcnt++;
            if (!prev && sck_out) begin
                if (sdo !== exp_bit(tx, lsb, ridx)) bad_bits++;
                if (ridx == 0) first_low = lowcnt;
                ridx++;
                if (ridx == 3 && mid_wr) begin
                    host_wdata = ~tx; host_wr = 1'b1;
                end
            end
            prev = sck_out;
            if (ridx < 8) @(negedge clk);
            cyc++;
        end
        host_wr = 1'b0;
        check(bad_bits == 0, lsb ? "R6 sent bits" : "R3 sent bits", bad_bits, 0);
        check(first_low == half_of(rate), "R2 half period", first_low, half_of(rate));
        check(done_flag == 1'b1, "R5 flag at eighth rise", done_flag, 1);
        if (mid_wr)
            check(host_rdata == peer, "R8 write ignored", host_rdata, peer);
        else
            check(host_rdata == peer, lsb ? "R6 received" : "R4 received", host_rdata, peer);
        begin
            int edges = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (!sck_out) edges++;
            end
            check(edges == 0, "R5 clock rests high", edges, 0);
        end
    endtask

    task automatic run_slave(input logic lsb, input logic [7:0] tx, input logic [7:0] peer);
        int bad_bits = 0;
        cfg_master = 1'b0; cfg_lsb_first = lsb;
        pulse_write(tx);
        repeat (2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            sck_in = 1'b0;
            sdi    = exp_bit(peer, lsb, i);
            repeat (6) @(negedge clk);
            if (sdo !== exp_bit(tx, lsb, i)) bad_bits++;
            sck_in = 1'b1;
            repeat (6) @(negedge clk);
        end
        check(bad_bits == 0, "R7 slave sent bits", bad_bits, 0);
        check(done_flag == 1'b1, "R7 slave flag", done_flag, 1);
        check(host_rdata == peer, "R7 slave received", host_rdata, peer);
        check(sck_out == 1'b1 && sck_oe == 1'b0, "R7 slave clock pin", {sck_out, sck_oe}, 2);
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd7);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(done_flag == 1'b0, "R1 reset flag", done_flag, 0);
        check(sck_out == 1'b1, "R1 reset clock", sck_out, 1);
        check(sdo == 1'b1, "R1 reset data", sdo, 1);

        // R10: disabled port ignores writes
        pulse_write(8'hA5);
        begin
            int lows = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (!sck_out) lows++;
            end
            check(lows == 0 && done_flag == 1'b0, "R10 disabled no transfer", lows, 0);
        end
        cfg_enable = 1'b1;
        begin
            int lows = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (!sck_out) lows++;
            end
            check(lows == 0, "R10 no pending start", lows, 0);
        end

        // Directed: every rate, both orders
        for (int r = 0; r < 4; r++) begin
            run_master(2'(r), 1'b0, 8'h96, 8'h3C, 1'b0);
            run_master(2'(r), 1'b1, 8'h96, 8'h3C, 1'b0);
            do_read();
        end
        // Corners: all ones / all zeros, and a write mid transfer
        run_master(2'd1, 1'b0, 8'hFF, 8'h00, 1'b0);
        run_master(2'd0, 1'b1, 8'h00, 8'hFF, 1'b0);
        run_master(2'd2, 1'b0, 8'h5A, 8'hC3, 1'b1);
        run_master(2'd0, 1'b1, 8'h81, 8'h7E, 1'b1);
        do_read();

        run_slave(1'b0, 8'hB4, 8'h2D);
        run_slave(1'b1, 8'hB4, 8'h2D);
        do_read();

        // Random mix
        for (int n = 0; n < 10; n++) begin
            logic [7:0] a, b;
            a = 8'($urandom);
            b = 8'($urandom);
            run_master(2'($urandom), 1'($urandom), a, b, 1'($urandom));
            if (n % 2 == 0) do_read();
        end
        for (int n = 0; n < 4; n++) begin
            logic [7:0] a, b;
            a = 8'($urandom);
            b = 8'($urandom);
            run_slave(1'($urandom), a, b);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule